// File: doc/BRIEF.md
# 16-Bit Up-Counting Timer Core

This block is an up-counter that counts clock cycles and raises an update event each time it passes a programmable limit. The count runs on every clock while it is enabled. When the count equals the active reload limit, the next step returns it to zero, sets a sticky status flag and pulses a one-cycle event output. Software can also force an update through a trigger register. That clears the count and runs the same event path. A preload option decides when a new limit is used. With preload off, a new limit applies as soon as it is written. With preload on, the new limit waits in a buffer until the next update event. A one-shot option makes the timer clear its own enable at its first update event. A debug-halt input, when combined with a freeze-enable input, stops the count.

Software reaches the block through a plain register port. The write strobe is always accepted in the cycle it is raised, so there is no back-pressure. The read port is combinational. Register indices: 0 control, 1 status, 2 trigger (write only), 3 count (read only), 4 reload limit. An access size code goes with each access: 0 is an 8-bit access, 1 is 16-bit, 2 or 3 is 32-bit.

Top module: `timer16_core`

## Requirements
- R1: After reset the control register reads 0x0000, the count reads 0, the reload limit reads 0xFFFF, the status flag is 0 and the event output is low.
- R2: Control bits hold their meaning at fixed positions:
  - bit 0: count enable
  - bit 1: update inhibit
  - bit 2: flag on overflow only
  - bit 3: one-shot
  - bit 7: reload preload
  Every other control bit reads 0.
- R3: The count rises by exactly one per clock while enable is set and the count is not frozen. With enable clear, it holds its value.
- R4: When a running count equals the active limit, the next clock returns it to 0. On that same clock, status bit 0 is set and the event output goes high for one cycle.
- R5: With preload clear, a write to the reload limit becomes the active limit on the clock of the write.
- R6: With preload set, a written limit goes into a buffer and does not change the active limit. The buffer moves into the active limit at the next update event. Reads of index 4 return the buffer.
- R7: With one-shot set, the enable bit clears itself at the update event. The count then stays at 0.
- R8: While debug-halt and freeze-enable are both high, the count holds. With freeze-enable low, halt has no effect on counting.
- R9: Writing 1 to bit 0 of the trigger register clears the count on that clock. It also produces an update event: the flag, the event pulse and, with preload set, the load of the active limit.
- R10: While update inhibit is set, the count still wraps and a trigger still clears it. No flag, no pulse, no limit load and no one-shot stop take place.
- R11: With flag-on-overflow-only set, a trigger clears the count and pulses the event output but leaves the status flag unchanged.
- R12: A write with the 8-bit size code is ignored. An 8-bit read returns the low byte of the register. A 16-bit or 32-bit read returns the register zero-extended.
- R13: Status bit 0 stays set until a write of 0 to it. Writing 1 has no effect. If an update event falls on the same clock as a clearing write, the flag is set.
- R14: If a trigger and a limit match fall on the same clock while flag-on-overflow-only is set, the flag is set and the count is cleared once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count runs at this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, accepted in one cycle |
| bus_waddr | input | 3 | Write register index |
| bus_wdata | input | 16 | Write data |
| bus_wsize | input | 2 | Write size code (0 = 8-bit, ignored) |
| bus_raddr | input | 3 | Read register index |
| bus_rsize | input | 2 | Read size code |
| bus_rdata | output | 32 | Combinational read data |
| dbg_halt | input | 1 | Debug halt request |
| dbg_freeze_en | input | 1 | Lets debug halt freeze the count |
| upd_pulse | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Sticky update flag (status bit 0) |

## Verification
Two functions can fall on the same clock: a software trigger and a limit match. Each could clear the count, and they disagree on whether the flag may be set. The bench raises both together: it runs the count up to a small limit and, with flag-on-overflow-only set, writes the trigger at the negative edge just before the match clock. A flag of 1, a single event pulse and a count of 0 followed by 1 pass. A missing flag or a skipped count fails. The same idea checks a clearing status write that lands on a wrap: the flag must stay set.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  localparam int REG_IDX_W = 3;
  localparam int BUS_DW = 16;
  localparam int RD_W = 32;

  typedef enum logic [REG_IDX_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_TRIG   = 3'd2,
    A_COUNT  = 3'd3,
    A_RELOAD = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // control bit positions are software visible
  localparam int B_EN      = 0;
  localparam int B_NOUPD   = 1;
  localparam int B_OVFONLY = 2;
  localparam int B_ONESHOT = 3;
  localparam int B_PRELOAD = 7;

  typedef struct packed {
    logic preload;
    logic oneshot;
    logic ovf_only;
    logic no_upd;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/timer16_reload.sv
module timer16_reload #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             preload,
  input  logic             upd_evt,
  output logic [CNT_W-1:0] active,
  output logic [CNT_W-1:0] buffered
);
  localparam logic [CNT_W-1:0] RST_LIMIT = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buffered <= RST_LIMIT;
      active   <= RST_LIMIT;
    end else begin
      if (wr) buffered <= wdata;
      if (wr && !preload) active <= wdata;
      else if (upd_evt)   active <= buffered;
    end
  end

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !upd_evt) |=> $stable(active));
  p_direct_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !preload) |=> (active == $past(wdata)));
endmodule

// File: rtl/timer16_count.sv
module timer16_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             no_upd,
  input  logic             ovf_only,
  input  logic             trig,
  input  logic             halt,
  input  logic             freeze_en,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_evt,
  output logic             flag_set,
  output logic             upd_pulse
);
  logic run, hit;

  always_comb begin
    run      = en && !(halt && freeze_en);
    hit      = run && (cnt == limit);
    upd_evt  = (hit || trig) && !no_upd;
    flag_set = upd_evt && (hit || !ovf_only);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= upd_evt;
      if (trig || hit) cnt <= '0;
      else if (run)    cnt <= cnt + 1'b1;
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hit && !trig) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !trig) |=> $stable(cnt));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && freeze_en && !trig) |=> $stable(cnt));
  p_trig_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == '0));
endmodule

// File: rtl/timer16_regs.sv
module timer16_regs
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_addr,
  input  logic [BUS_DW-1:0]    wr_data,
  input  logic [1:0]           wr_size,
  input  logic [REG_IDX_W-1:0] rd_addr,
  input  logic [1:0]           rd_size,
  input  logic                 upd_evt,
  input  logic                 flag_set,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [CNT_W-1:0]     reload_view,
  output ctrl_t                ctrl,
  output logic                 trig,
  output logic                 reload_wr,
  output logic [CNT_W-1:0]     reload_wdata,
  output logic                 flag,
  output logic [RD_W-1:0]      rd_data
);
  logic wr_ok, ctrl_wr, stat_clr;
  ctrl_t ctrl_d;
  logic [RD_W-1:0] full;

  always_comb begin
    wr_ok        = wr_en && (wr_size != SZ_BYTE);
    ctrl_wr      = wr_ok && (wr_addr == A_CTRL);
    stat_clr     = wr_ok && (wr_addr == A_STAT) && !wr_data[0];
    trig         = wr_ok && (wr_addr == A_TRIG) && wr_data[0];
    reload_wr    = wr_ok && (wr_addr == A_RELOAD);
    reload_wdata = wr_data[CNT_W-1:0];
    ctrl_d       = ctrl;
    if (ctrl_wr) begin
      ctrl_d.en       = wr_data[B_EN];
      ctrl_d.no_upd   = wr_data[B_NOUPD];
      ctrl_d.ovf_only = wr_data[B_OVFONLY];
      ctrl_d.oneshot  = wr_data[B_ONESHOT];
      ctrl_d.preload  = wr_data[B_PRELOAD];
    end
    if (upd_evt && ctrl.oneshot) ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      ctrl <= ctrl_d;
      if (flag_set)      flag <= 1'b1;
      else if (stat_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    full = '0;
    case (rd_addr)
      A_CTRL: begin
        full[B_EN]      = ctrl.en;
        full[B_NOUPD]   = ctrl.no_upd;
        full[B_OVFONLY] = ctrl.ovf_only;
        full[B_ONESHOT] = ctrl.oneshot;
        full[B_PRELOAD] = ctrl.preload;
      end
      A_STAT:   full[0] = flag;
      A_COUNT:  full = RD_W'(cnt);
      A_RELOAD: full = RD_W'(reload_view);
      default:  full = '0;
    endcase
    case (rd_size)
      SZ_BYTE: rd_data = {{(RD_W-8){1'b0}}, full[7:0]};
      SZ_HALF: rd_data = {{(RD_W-16){1'b0}}, full[15:0]};
      default: rd_data = full;
    endcase
  end

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && ctrl.oneshot) |=> !ctrl.en);
  p_byte_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == SZ_BYTE && !upd_evt) |=> $stable(ctrl));
  p_flag_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stat_clr) |=> flag);
  p_flag_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag);
endmodule

// File: rtl/timer16_core.sv
module timer16_core
  import timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [REG_IDX_W-1:0] bus_waddr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  input  logic [1:0]           bus_wsize,
  input  logic [REG_IDX_W-1:0] bus_raddr,
  input  logic [1:0]           bus_rsize,
  output logic [RD_W-1:0]      bus_rdata,
  input  logic                 dbg_halt,
  input  logic                 dbg_freeze_en,
  output logic                 upd_pulse,
  output logic                 upd_flag
);
  ctrl_t ctrl;
  logic trig, reload_wr, upd_evt, flag_set;
  logic [CNT_W-1:0] reload_wdata, limit_act, limit_buf, cnt;

  timer16_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_waddr), .wr_data(bus_wdata), .wr_size(bus_wsize),
    .rd_addr(bus_raddr), .rd_size(bus_rsize),
    .upd_evt(upd_evt), .flag_set(flag_set), .cnt(cnt), .reload_view(limit_buf),
    .ctrl(ctrl), .trig(trig), .reload_wr(reload_wr), .reload_wdata(reload_wdata),
    .flag(upd_flag), .rd_data(bus_rdata)
  );

  timer16_reload #(.CNT_W(CNT_W)) u_reload (
    .clk(clk), .rst_n(rst_n), .wr(reload_wr), .wdata(reload_wdata),
    .preload(ctrl.preload), .upd_evt(upd_evt),
    .active(limit_act), .buffered(limit_buf)
  );

  timer16_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .no_upd(ctrl.no_upd),
    .ovf_only(ctrl.ovf_only), .trig(trig), .halt(dbg_halt),
    .freeze_en(dbg_freeze_en), .limit(limit_act), .cnt(cnt),
    .upd_evt(upd_evt), .flag_set(flag_set), .upd_pulse(upd_pulse)
  );

  p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.no_upd |=> !upd_pulse);
  p_pulse_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && !$past(trig)) |-> (cnt == '0));
endmodule

// File: tb/sim_timer16_core.sv
module sim_timer16_core;
  localparam int CLK_P = 10;
  localparam logic [2:0] I_CTRL = 3'd0, I_STAT = 3'd1, I_TRIG = 3'd2, I_CNT = 3'd3, I_REL = 3'd4;
  localparam logic [1:0] S_B = 2'd0, S_H = 2'd1, S_W = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_waddr = '0, bus_raddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0] bus_wsize = S_H, bus_rsize = S_H;
  logic [31:0] bus_rdata;
  logic dbg_halt = 1'b0, dbg_freeze_en = 1'b0;
  logic upd_pulse, upd_flag;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  timer16_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_wsize(bus_wsize), .bus_raddr(bus_raddr),
    .bus_rsize(bus_rsize), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .dbg_freeze_en(dbg_freeze_en), .upd_pulse(upd_pulse), .upd_flag(upd_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] s = S_H);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; bus_wsize = s;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] v);
    bus_raddr = a; bus_rsize = s;
    #1 v = bus_rdata;
  endtask

  task automatic cnt_is(input string tag, input int exp);
    logic [31:0] v;
    rd(I_CNT, S_W, v);
    chk(tag, v, 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; dbg_halt = 1'b0; dbg_freeze_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(I_CTRL, S_W, v); chk("R1 ctrl", v, 32'h0);
    rd(I_REL, S_W, v);  chk("R1 reload", v, 32'h0000FFFF);
    rd(I_STAT, S_W, v); chk("R1 status", v, 32'h0);
    cnt_is("R1 count", 0);
    chk("R1 pulse", 32'(upd_pulse), 32'h0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] v;
    do_reset();
    wr(I_CTRL, 16'hFFFE);
    rd(I_CTRL, S_W, v); chk("R2 reserved bits zero", v, 32'h0000008E);
  endtask

  task automatic t_count();
    do_reset();
    wr(I_CTRL, 16'h0001);
    tick(5); cnt_is("R3 five steps", 5);
    wr(I_CTRL, 16'h0000);
    cnt_is("R3 last step", 6);
    tick(3); cnt_is("R3 hold when disabled", 6);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    do_reset();
    wr(I_REL, 16'd3);
    wr(I_CTRL, 16'h0001);
    tick(3); cnt_is("R4 at limit", 3);
    chk("R4 no early flag", 32'(upd_flag), 0);
    tick(1); cnt_is("R4 wrapped", 0);
    chk("R4 pulse high", 32'(upd_pulse), 1);
    rd(I_STAT, S_W, v); chk("R4 status bit", v, 1);
    tick(1); chk("R4 pulse one cycle", 32'(upd_pulse), 0);
    chk("R13 flag sticky", 32'(upd_flag), 1);
    tick(1);
    wr(I_STAT, 16'h0001);
    chk("R13 write one keeps", 32'(upd_flag), 1);
    wr(I_STAT, 16'h0000);
    cnt_is("R13 wrap on clear cycle", 0);
    chk("R13 set wins over clear", 32'(upd_flag), 1);
    wr(I_STAT, 16'h0000);
    chk("R13 write zero clears", 32'(upd_flag), 0);
  endtask

  task automatic t_direct();
    do_reset();
    wr(I_CTRL, 16'h0001);
    tick(4);
    wr(I_REL, 16'd6);
    tick(1); cnt_is("R5 reach new limit", 6);
    tick(1); cnt_is("R5 wrap at new limit", 0);
    chk("R5 pulse", 32'(upd_pulse), 1);
  endtask

  task automatic t_preload();
    logic [31:0] v;
    do_reset();
    wr(I_REL, 16'd2);
    wr(I_CTRL, 16'h0080);
    wr(I_REL, 16'd5);
    rd(I_REL, S_W, v); chk("R6 buffer read", v, 5);
    wr(I_CTRL, 16'h0081);
    tick(3); cnt_is("R6 old limit used", 0);
    chk("R6 pulse on old limit", 32'(upd_pulse), 1);
    tick(3); cnt_is("R6 new limit loaded", 3);
    tick(2); cnt_is("R6 up to new limit", 5);
    tick(1); cnt_is("R6 wrap at new limit", 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    do_reset();
    wr(I_REL, 16'd2);
    wr(I_CTRL, 16'h0009);
    tick(3); cnt_is("R7 wrapped", 0);
    rd(I_CTRL, S_W, v); chk("R7 enable cleared", v, 32'h8);
    tick(3); cnt_is("R7 stays stopped", 0);
  endtask

  task automatic t_halt();
    do_reset();
    dbg_freeze_en = 1'b1;
    wr(I_CTRL, 16'h0001);
    tick(2); cnt_is("R8 before halt", 2);
    dbg_halt = 1'b1;
    tick(3); cnt_is("R8 frozen", 2);
    dbg_freeze_en = 1'b0;
    tick(2); cnt_is("R8 halt ignored", 4);
    dbg_halt = 1'b0;
  endtask

  task automatic t_trig();
    do_reset();
    wr(I_CTRL, 16'h0001);
    tick(4);
    wr(I_TRIG, 16'h0001);
    cnt_is("R9 count cleared", 0);
    chk("R9 pulse", 32'(upd_pulse), 1);
    chk("R9 flag", 32'(upd_flag), 1);
    tick(1); cnt_is("R9 resumes", 1);
    do_reset();
    wr(I_CTRL, 16'h0080);
    wr(I_REL, 16'd2);
    wr(I_TRIG, 16'h0001);
    wr(I_CTRL, 16'h0081);
    tick(3); cnt_is("R9 trigger loaded limit", 0);
    chk("R9 pulse at loaded limit", 32'(upd_pulse), 1);
  endtask

  task automatic t_noupd();
    logic [31:0] v;
    do_reset();
    wr(I_REL, 16'd2);
    wr(I_CTRL, 16'h000B);
    tick(3); cnt_is("R10 still wraps", 0);
    chk("R10 no pulse", 32'(upd_pulse), 0);
    chk("R10 no flag", 32'(upd_flag), 0);
    rd(I_CTRL, S_W, v); chk("R10 no oneshot stop", v, 32'hB);
    tick(2);
    wr(I_TRIG, 16'h0001);
    cnt_is("R10 trigger clears", 0);
    chk("R10 trigger no pulse", 32'(upd_pulse), 0);
  endtask

  task automatic t_src();
    do_reset();
    wr(I_CTRL, 16'h0005);
    tick(4);
    wr(I_TRIG, 16'h0001);
    cnt_is("R11 trigger clears", 0);
    chk("R11 no flag", 32'(upd_flag), 0);
    chk("R11 pulse", 32'(upd_pulse), 1);
    do_reset();
    wr(I_REL, 16'd3);
    wr(I_CTRL, 16'h0005);
    tick(3);
    wr(I_TRIG, 16'h0001);
    cnt_is("R14 cleared", 0);
    chk("R14 flag from match", 32'(upd_flag), 1);
    tick(1); cnt_is("R14 single clear", 1);
  endtask

  task automatic t_access();
    logic [31:0] v;
    do_reset();
    wr(I_CTRL, 16'h0001, S_B);
    rd(I_CTRL, S_W, v); chk("R12 byte ctrl write ignored", v, 0);
    tick(2); cnt_is("R12 not counting", 0);
    wr(I_REL, 16'h0012, S_B);
    rd(I_REL, S_B, v); chk("R12 byte read", v, 32'hFF);
    rd(I_REL, S_H, v); chk("R12 half read", v, 32'hFFFF);
    wr(I_REL, 16'h1234, S_H);
    rd(I_REL, S_B, v); chk("R12 byte low lane", v, 32'h34);
    rd(I_REL, S_W, v); chk("R12 word read", v, 32'h1234);
    wr(I_CTRL, 16'h0001, S_W);
    tick(2); cnt_is("R12 word write accepted", 2);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_ctrl_bits();
    t_count();
    t_wrap();
    t_direct();
    t_preload();
    t_oneshot();
    t_halt();
    t_trig();
    t_noupd();
    t_src();
    t_access();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule